// File: doc/BRIEF.md
# Two-Tier DRAM Row Cache Controller

This block models the per-bank control for a DRAM subarray whose bitlines are split by an isolation switch. The split gives a small, fast near segment beside the sense amplifiers and a large, slow far segment behind the switch. The near segment works as a hardware-managed cache of far rows. A fully associative tag table records which far rows currently have a copy in the near segment.

Row requests arrive on a valid/ready handshake. The tag lookup takes place in the cycle the request is accepted. Rows below the near-segment size address the near segment directly. Far rows that hit in the tag table are served at near latency with the isolation switch open. Far rows that miss are served at far latency with the switch closed. After the miss completes, the block runs an in-bank copy of that row into a victim slot, and no further request is accepted until the copy ends. The copy stays inside the bank. The block also keeps hit and miss counters so the hit rate can be measured.

Top module: `tier_row_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, `iso_on`, `done` and `xfer_active` are 0, both counters read 0, and every tag slot is invalid.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the access, and any copy that follows it, has finished.
- R3: A request whose row index is below 32 (NEAR_ROWS) bypasses the tag table. `done` is 1 with `done_near`=1 in the 6th cycle (NEAR_LAT) after the accept edge, `iso_on` stays 0, and neither counter changes.
- R4: A far row (index 32 or above) that is found in the tag table completes in the NEAR_LAT-th cycle with `done_near`=1 and `iso_on` at 0. It increments `hit_count` by one and starts no copy.
- R5: A far row that is not in the tag table holds `iso_on` at 1 and completes in the 17th cycle (FAR_LAT) after the accept edge with `done_near`=0. It increments `miss_count` by one.
- R6: After a miss completes, `xfer_active` is 1 for the next 18 cycles (COPY_LAT). During that window `iso_on` is 1, `xfer_row` shows the missed row and `xfer_slot` shows the destination slot. Once the copy ends, the same row hits.
- R7: The copy destination is the lowest-numbered invalid tag slot, if any slot is invalid.
- R8: When every slot is valid, the copy destination is the least-recently-used slot. Both a hit and a completed copy count as a use.
- R9: Each counter changes by at most one per cycle, and only when a request is accepted.
- R10: A reset asserted during a copy aborts it, invalidates the table and clears the counters. The aborted row then misses again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_row | input | 9 | Row index within the subarray (0..511) |
| req_ready | output | 1 | Block idle and able to take a request |
| done | output | 1 | One-cycle completion strobe of the access |
| done_near | output | 1 | With `done`: 1 if served by the near tier |
| iso_on | output | 1 | Isolation switch closed (far segment connected) |
| xfer_active | output | 1 | In-bank segment-to-segment copy in progress |
| xfer_row | output | 9 | Far row being copied |
| xfer_slot | output | 5 | Near-segment slot receiving the copy |
| hit_count | output | 16 | Far-row requests found in the tag table |
| miss_count | output | 16 | Far-row requests not found in the tag table |

## Verification
The assertions check the following on every cycle:
- at most one tag slot matches a lookup;
- the recency ages always single out exactly one oldest slot;
- the busy timer counts down one step per cycle;
- a far completion is always followed by a copy with the switch closed;
- the copy's row and slot hold steady;
- the counters never jump.

Only the directed scenarios can show the exact latencies and the slot a miss lands in. This covers invalid slots filling in index order, then least-recently-used eviction after a recent hit reorders the ages. The scenarios also show that rows 31 and 32 fall on opposite sides of the tier boundary and that a reset during a copy really discards the row being installed.

// File: rtl/tier_pkg.sv
package tier_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_COPY   = 2'd2
   } tier_state_e;
endpackage

// File: rtl/tier_busy_timer.sv
module tier_busy_timer #(
   parameter int LAT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LAT_W-1:0] load_val,
   output logic             last
);
   logic [LAT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == LAT_W'(1));

   // R2: a running count steps down by exactly one each cycle
   a_r2_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0 && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tier_tag_table.sv
module tier_tag_table #(
   parameter int SLOTS = 32,
   parameter int ROW_W = 9,
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ROW_W-1:0]  look_row,
   output logic              hit,
   output logic [SLOT_W-1:0] hit_slot,
   output logic [SLOT_W-1:0] victim_slot,
   input  logic              touch_en,
   input  logic [SLOT_W-1:0] touch_slot,
   input  logic              fill_en,
   input  logic [SLOT_W-1:0] fill_slot,
   input  logic [ROW_W-1:0]  fill_row
);
   localparam logic [SLOT_W-1:0] OLDEST = SLOT_W'(SLOTS - 1);

   if ((1 << SLOT_W) != SLOTS) begin : g_bad_slots
      $error("tier_tag_table: SLOTS must be a power of two");
   end

   logic              vld_q   [SLOTS];
   logic [ROW_W-1:0]  tag_q   [SLOTS];
   logic [SLOT_W-1:0] age_q   [SLOTS];
   logic [SLOTS-1:0]  match_vec;
   logic [SLOTS-1:0]  oldest_vec;
   logic [SLOT_W-1:0] touch_age;

   assign touch_age = age_q[touch_slot];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign match_vec[g]  = vld_q[g] && (tag_q[g] == look_row);
      assign oldest_vec[g] = (age_q[g] == OLDEST);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[g] <= 1'b0;
            tag_q[g] <= '0;
            age_q[g] <= SLOT_W'(g);
         end else begin
            if (fill_en && fill_slot == SLOT_W'(g)) begin
               vld_q[g] <= 1'b1;
               tag_q[g] <= fill_row;
            end
            if (touch_en) begin
               if (touch_slot == SLOT_W'(g))  age_q[g] <= '0;
               else if (age_q[g] < touch_age) age_q[g] <= age_q[g] + 1'b1;
            end
         end
      end
   end

   always_comb begin
      hit      = |match_vec;
      hit_slot = '0;
      for (int i = 0; i < SLOTS; i++)
         if (match_vec[i]) hit_slot = hit_slot | SLOT_W'(i);
   end

   always_comb begin
      victim_slot = '0;
      for (int i = SLOTS - 1; i >= 0; i--)
         if (oldest_vec[i]) victim_slot = SLOT_W'(i);
      for (int i = SLOTS - 1; i >= 0; i--)
         if (!vld_q[i]) victim_slot = SLOT_W'(i);
   end

   // R6: a row is never held in two slots at once
   a_r6_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));
   // R8: the recency ages always name exactly one oldest slot
   a_r8_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest_vec) == 1);
endmodule

// File: rtl/tier_row_ctrl.sv
module tier_row_ctrl #(
   parameter int ROWS      = 512,
   parameter int NEAR_ROWS = 32,
   parameter int NEAR_LAT  = 6,
   parameter int FAR_LAT   = 17,
   parameter int COPY_LAT  = FAR_LAT + 1,
   parameter int CNT_W     = 16,
   localparam int ROW_W    = $clog2(ROWS),
   localparam int SLOT_W   = $clog2(NEAR_ROWS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ROW_W-1:0]  req_row,
   output logic              req_ready,
   output logic              done,
   output logic              done_near,
   output logic              iso_on,
   output logic              xfer_active,
   output logic [ROW_W-1:0]  xfer_row,
   output logic [SLOT_W-1:0] xfer_slot,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count
);
   import tier_pkg::*;

   localparam int LAT_W = $clog2(COPY_LAT + 1);
   localparam logic [ROW_W-1:0] NEAR_LIM = ROW_W'(NEAR_ROWS);

   if (NEAR_LAT < 1 || FAR_LAT <= NEAR_LAT) begin : g_bad_lat
      $error("tier_row_ctrl: need 1 <= NEAR_LAT < FAR_LAT");
   end
   if (COPY_LAT <= FAR_LAT) begin : g_bad_copy
      $error("tier_row_ctrl: COPY_LAT must exceed FAR_LAT");
   end
   if (NEAR_ROWS >= ROWS) begin : g_bad_rows
      $error("tier_row_ctrl: near segment must be smaller than the subarray");
   end

   tier_state_e       state_q;
   logic              miss_q;
   logic [ROW_W-1:0]  row_q;
   logic [SLOT_W-1:0] slot_q;

   logic              accept, far_req, tag_hit, is_hit, is_miss;
   logic [SLOT_W-1:0] hit_slot, victim_slot, touch_slot;
   logic              touch_en, fill_en, t_load, t_last;
   logic [LAT_W-1:0]  t_val;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign far_req   = (req_row >= NEAR_LIM);
   assign is_hit    = accept && far_req && tag_hit;
   assign is_miss   = accept && far_req && !tag_hit;

   assign fill_en    = (state_q == ST_COPY) && t_last;
   assign touch_en   = is_hit || fill_en;
   assign touch_slot = fill_en ? slot_q : hit_slot;

   assign t_load = accept || ((state_q == ST_ACCESS) && t_last && miss_q);
   assign t_val  = !accept ? LAT_W'(COPY_LAT)
                 : (is_miss ? LAT_W'(FAR_LAT) : LAT_W'(NEAR_LAT));

   tier_tag_table #(.SLOTS(NEAR_ROWS), .ROW_W(ROW_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .look_row(req_row), .hit(tag_hit), .hit_slot(hit_slot),
      .victim_slot(victim_slot),
      .touch_en(touch_en), .touch_slot(touch_slot),
      .fill_en(fill_en), .fill_slot(slot_q), .fill_row(row_q)
   );

   tier_busy_timer #(.LAT_W(LAT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .last(t_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         miss_q     <= 1'b0;
         row_q      <= '0;
         slot_q     <= '0;
         hit_count  <= '0;
         miss_count <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept) begin
               state_q <= ST_ACCESS;
               miss_q  <= is_miss;
               row_q   <= req_row;
               slot_q  <= tag_hit ? hit_slot : victim_slot;
               if (is_hit)  hit_count  <= hit_count + 1'b1;
               if (is_miss) miss_count <= miss_count + 1'b1;
            end
            ST_ACCESS: if (t_last) state_q <= miss_q ? ST_COPY : ST_IDLE;
            ST_COPY:   if (t_last) state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   assign done        = (state_q == ST_ACCESS) && t_last;
   assign done_near   = done && !miss_q;
   assign iso_on      = ((state_q == ST_ACCESS) && miss_q) || (state_q == ST_COPY);
   assign xfer_active = (state_q == ST_COPY);
   assign xfer_row    = row_q;
   assign xfer_slot   = slot_q;

   // R2: completion only happens while the block is busy
   a_r2_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_ready);
   // R3: a direct near-segment request leaves the switch open
   a_r3_near_iso_off: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_row < NEAR_LIM) |=> !iso_on);
   // R4: a near-tier completion frees the block on the next cycle
   a_r4_near_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_near) |=> req_ready);
   // R6: a far completion is followed by a copy with the switch closed
   a_r6_copy_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_near) |=> (xfer_active && iso_on));
   // R6: the copy keeps its source row and destination slot
   a_r6_copy_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_active && $past(xfer_active)) |-> ($stable(xfer_row) && $stable(xfer_slot)));
   // R9: counters step by at most one
   a_r9_hit_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (hit_count == $past(hit_count) || hit_count == $past(hit_count) + 1'b1));
   a_r9_miss_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (miss_count == $past(miss_count) || miss_count == $past(miss_count) + 1'b1));
endmodule

// File: tb/tier_row_ctrl_test.sv
module tier_row_ctrl_test;
   localparam int NEAR = 6;
   localparam int FAR  = 17;
   localparam int COPY = 18;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [8:0] req_row = '0;
   logic       req_ready, done, done_near, iso_on, xfer_active;
   logic [8:0] xfer_row;
   logic [4:0] xfer_slot;
   logic [15:0] hit_count, miss_count;

   int n_checks = 0;
   int n_fail   = 0;
   int exp_hits = 0;
   int exp_miss = 0;

   always #5 clk = ~clk;

   tier_row_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
      .req_ready(req_ready), .done(done), .done_near(done_near), .iso_on(iso_on),
      .xfer_active(xfer_active), .xfer_row(xfer_row), .xfer_slot(xfer_slot),
      .hit_count(hit_count), .miss_count(miss_count)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_counters(input string req);
      check(hit_count == 16'(exp_hits), {req, " hit_count"}, hit_count, exp_hits);
      check(miss_count == 16'(exp_miss), {req, " miss_count"}, miss_count, exp_miss);
   endtask

   // kind: 0 direct near, 1 tag hit, 2 miss
   task automatic do_req(input int row, input int kind, input int exp_slot, input string req);
      int lat, total, bad_done, bad_iso, bad_ready, bad_xfer, near_seen;
      bit miss;
      miss  = (kind == 2);
      lat   = miss ? FAR : NEAR;
      total = lat + (miss ? COPY : 0) + 1;
      bad_done = 0; bad_iso = 0; bad_ready = 0; bad_xfer = 0; near_seen = -1;
      @(negedge clk);
      check(req_ready == 1'b1, {req, " R2 ready before accept"}, req_ready, 1);
      req_valid = 1'b1;
      req_row   = 9'(row);
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 1; k <= total; k++) begin
         if (k > 1) @(negedge clk);
         if (done !== (k == lat)) bad_done++;
         if (k == lat) near_seen = done_near;
         if (iso_on !== ((k <= lat) ? miss : (miss && k <= lat + COPY))) bad_iso++;
         if (req_ready !== (k == total)) bad_ready++;
         if (xfer_active !== (miss && k > lat && k <= lat + COPY)) bad_xfer++;
         if (miss && k == lat + 1) begin
            check(xfer_slot == 5'(exp_slot), {req, " xfer_slot"}, xfer_slot, exp_slot);
            check(xfer_row == 9'(row), "R6 xfer_row", xfer_row, row);
         end
      end
      if (kind == 1) exp_hits++;
      if (kind == 2) exp_miss++;
      check(bad_done == 0, {req, " done timing"}, bad_done, 0);
      check(near_seen == (miss ? 0 : 1), {req, " done_near"}, near_seen, miss ? 0 : 1);
      check(bad_iso == 0, {req, " iso_on"}, bad_iso, 0);
      check(bad_ready == 0, "R2 ready low while busy", bad_ready, 0);
      check(bad_xfer == 0, "R6 xfer window", bad_xfer, 0);
      check_counters({req, " R9"});
   endtask

   task automatic t_reset_state;
      @(negedge clk);
      check(req_ready == 1'b1, "R1 ready", req_ready, 1);
      check(iso_on == 1'b0, "R1 iso", iso_on, 0);
      check(done == 1'b0, "R1 done", done, 0);
      check(xfer_active == 1'b0, "R1 xfer", xfer_active, 0);
      check_counters("R1");
   endtask

   task automatic t_direct_near;
      do_req(5, 0, 0, "R3");
      do_req(31, 0, 0, "R3 boundary");
   endtask

   task automatic t_first_miss_then_hit;
      do_req(32, 2, 0, "R5 R7");
      do_req(32, 1, 0, "R4 R6");
   endtask

   task automatic t_fill_table;
      for (int i = 0; i < 31; i++) do_req(200 + i, 2, i + 1, "R7 fill");
   endtask

   task automatic t_lru;
      do_req(32, 1, 0, "R4 R8 touch");
      do_req(300, 2, 1, "R8 evict oldest");
      do_req(200, 2, 2, "R8 evicted row misses");
      do_req(32, 1, 0, "R8 recent row kept");
      do_req(300, 1, 1, "R8 installed row hits");
   endtask

   task automatic t_reset_mid_copy;
      int guard;
      @(negedge clk);
      req_valid = 1'b1;
      req_row   = 9'd400;
      @(negedge clk);
      req_valid = 1'b0;
      guard = 0;
      while (!xfer_active && guard < 40) begin
         @(negedge clk);
         guard++;
      end
      check(xfer_active == 1'b1, "R10 copy started", xfer_active, 1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      exp_hits = 0;
      exp_miss = 0;
      check(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
      check(xfer_active == 1'b0, "R10 copy aborted", xfer_active, 0);
      check(iso_on == 1'b0, "R10 iso", iso_on, 0);
      check_counters("R10");
      do_req(400, 2, 0, "R10 aborted row misses");
      do_req(32, 2, 1, "R10 R7 table cleared");
      do_req(400, 1, 0, "R10 R4 refill hits");
   endtask

   task automatic run_all;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_direct_near();
      t_first_miss_then_hit();
      t_fill_table();
      t_lru();
      t_reset_mid_copy();
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         end
      join_any
      disable fork;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule